// File: doc/BRIEF.md
# Foreground Gain Calibration Sequencer

This block measures the gain and offset of two converter stages while normal conversion is paused. It steps a digital ramp code into an external ramp source, takes one converter result per ramp step through a valid/ready sample input, and keeps running sums of the samples. At the end of each ramp it fits a straight line, measured output against ramp value, by least squares. A sequential shift-subtract divider then produces a signed fixed-point gain and offset for that stage.

The order is fixed. The last stage is measured first with a coarse ramp of `COARSE_STEPS` steps spaced `COARSE_STRIDE` codes apart (16 steps of 8 by default). The middle stage follows with a fine ramp of `FINE_STEPS` steps spaced `FINE_STRIDE` apart (128 steps of 1 by default). All four coefficients are replaced together in the cycle that `done` pulses. Logic outside this block applies them as a multiply-add.

Sample back-pressure: `sample_ready` is high only while the block waits for the result of the current ramp step. A sample transfers on a cycle where `sample_valid` and `sample_ready` are both high. The source must hold `sample_data` stable while `sample_valid` is high without `sample_ready`. After the final step of a ramp, `sample_ready` stays low until the fit for that stage is complete.

Top module: `gain_cal_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `sample_ready` are 0 and `ramp_code` is 0. Both gains equal 1.0, which is the value 2^FRAC_W in two's complement with FRAC_W fraction bits. Both offsets are 0.
- R2: A `start` seen while idle makes `busy` 1 from the next cycle until completion. In the completion cycle `done` is 1 and `busy` is 0.
- R3: Accepted samples see ramp codes in a fixed order: k*COARSE_STRIDE for k = 0..COARSE_STEPS-1, then k*FINE_STRIDE for k = 0..FINE_STEPS-1. `ramp_code` changes only after an accepted sample, and it is 0 whenever the block is idle.
- R4: `sample_ready` is 1 only while `busy` is 1 and the block awaits a ramp-step sample. Each transfer advances the ramp by exactly one step on the next cycle.
- R5: Each stage gain is trunc(2^FRAC_W*(N*Sxy - Sx*Sy)/(N*Sxx - Sx^2)), rounded toward zero. The sums run over that stage's accepted samples, with x the ramp code and y the unsigned sample.
- R6: Each stage offset is trunc(2^FRAC_W*(Sxx*Sy - Sx*Sxy)/(N*Sxx - Sx^2)), rounded toward zero and in the same units.
- R7: Any coefficient whose magnitude exceeds 2^(COEF_W-1)-1 saturates to +/-(2^(COEF_W-1)-1).
- R8: A `start` while `busy` is ignored. Coefficient outputs keep their previous values until the `done` cycle and change in no other cycle.
- R9: `last_gain`/`last_offset` come from the coarse ramp and `mid_gain`/`mid_offset` from the fine ramp.
- R10: Samples offered while idle are not accepted. They leave the ramp and the coefficients unchanged and do not enter the next fit.
- R11: `done` is high for exactly one cycle per calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Calibration request, taken only while idle |
| sample_valid | input | 1 | Converter result present |
| sample_ready | output | 1 | Block can accept the result for the current ramp step |
| sample_data | input | SAMPLE_W | Unsigned converter result |
| ramp_code | output | CODE_W | Digital code for the external ramp source |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| last_gain | output | COEF_W | Signed gain, last stage |
| last_offset | output | COEF_W | Signed offset, last stage |
| mid_gain | output | COEF_W | Signed gain, middle stage |
| mid_offset | output | COEF_W | Signed offset, middle stage |

## Verification
The bench keeps the default ramp shapes (16 steps of 8, then 128 steps of 1), `FRAC_W` of 8 and 12-bit samples. It narrows `COEF_W` to 20 bits. At that width a step-shaped fine-ramp response pushes the middle-stage offset past the coefficient limit, so saturation is exercised, while straight, sloped, negative-slope and curved responses still fit. Samples arrive with varying idle gaps so that the design must wait for each step's result.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SOLVE,
    ST_GAIN_GO,
    ST_GAIN_WAIT,
    ST_OFS_GO,
    ST_OFS_WAIT,
    ST_WRAP
  } cal_state_t;

  typedef enum logic {
    STG_LAST = 1'b0,
    STG_MID  = 1'b1
  } cal_stage_t;
endpackage

// File: rtl/gcal_ramp.sv
module gcal_ramp #(
  parameter int CODE_W        = 8,
  parameter int COARSE_STEPS  = 16,
  parameter int COARSE_STRIDE = 8,
  parameter int FINE_STEPS    = 128,
  parameter int FINE_STRIDE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic              fine,
  output logic [CODE_W-1:0] code,
  output logic              at_end
);
  localparam int MAX_STEPS = (COARSE_STEPS > FINE_STEPS) ? COARSE_STEPS : FINE_STEPS;
  localparam int IDX_W     = (MAX_STEPS > 2) ? $clog2(MAX_STEPS) : 1;
  localparam logic [IDX_W-1:0]  C_LAST = IDX_W'(COARSE_STEPS - 1);
  localparam logic [IDX_W-1:0]  F_LAST = IDX_W'(FINE_STEPS - 1);
  localparam logic [CODE_W-1:0] C_STR  = CODE_W'(COARSE_STRIDE);
  localparam logic [CODE_W-1:0] F_STR  = CODE_W'(FINE_STRIDE);

  logic [IDX_W-1:0] idx_q;

  always_comb begin
    code   = CODE_W'(idx_q) * (fine ? F_STR : C_STR);
    at_end = (idx_q == (fine ? F_LAST : C_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (clear)   idx_q <= '0;
    else if (advance) idx_q <= at_end ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/gcal_accum.sv
module gcal_accum #(
  parameter int CODE_W   = 8,
  parameter int SAMPLE_W = 12,
  parameter int NCNT_W   = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clear,
  input  logic                               take,
  input  logic [CODE_W-1:0]                  x,
  input  logic [SAMPLE_W-1:0]                y,
  output logic [NCNT_W-1:0]                  n,
  output logic [CODE_W+NCNT_W-1:0]           sx,
  output logic [SAMPLE_W+NCNT_W-1:0]         sy,
  output logic [2*CODE_W+NCNT_W-1:0]         sxx,
  output logic [CODE_W+SAMPLE_W+NCNT_W-1:0]  sxy
);
  localparam int SX_W  = CODE_W + NCNT_W;
  localparam int SY_W  = SAMPLE_W + NCNT_W;
  localparam int SXX_W = 2*CODE_W + NCNT_W;
  localparam int SXY_W = CODE_W + SAMPLE_W + NCNT_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n <= '0; sx <= '0; sy <= '0; sxx <= '0; sxy <= '0;
    end else if (clear) begin
      n <= '0; sx <= '0; sy <= '0; sxx <= '0; sxy <= '0;
    end else if (take) begin
      n   <= n + 1'b1;
      sx  <= sx + SX_W'(x);
      sy  <= sy + SY_W'(y);
      sxx <= sxx + SXX_W'(x) * SXX_W'(x);
      sxy <= sxy + SXY_W'(x) * SXY_W'(y);
    end
  end
endmodule

// File: rtl/gcal_div.sv
module gcal_div #(
  parameter int NUM_W  = 45,
  parameter int DEN_W  = 45,
  parameter int FRAC_W = 8,
  parameter int COEF_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic signed [NUM_W-1:0]  numer,
  input  logic [DEN_W-1:0]         denom,
  output logic                     fin,
  output logic signed [COEF_W-1:0] quot
);
  localparam int DVD_W = NUM_W + FRAC_W;
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam logic [DVD_W-1:0] LIM = {{(DVD_W-COEF_W+1){1'b0}}, {(COEF_W-1){1'b1}}};

  logic [DVD_W-1:0] dvd_q, quo_q, mag_sat;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W:0]   rem_sh;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, neg_q, fit;
  logic [NUM_W-1:0] mag_in;

  always_comb begin
    mag_in  = numer[NUM_W-1] ? NUM_W'(-numer) : NUM_W'(numer);
    rem_sh  = {rem_q, dvd_q[DVD_W-1]};
    fit     = (rem_sh >= {1'b0, denom});
    mag_sat = (quo_q > LIM) ? LIM : quo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0; quo_q <= '0; rem_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; neg_q <= 1'b0; fin <= 1'b0; quot <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        dvd_q <= {mag_in, {FRAC_W{1'b0}}};
        quo_q <= '0;
        rem_q <= '0;
        cnt_q <= CNT_W'(DVD_W);
        neg_q <= numer[NUM_W-1];
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q != '0) begin
          rem_q <= fit ? DEN_W'(rem_sh - {1'b0, denom}) : rem_sh[DEN_W-1:0];
          quo_q <= {quo_q[DVD_W-2:0], fit};
          dvd_q <= {dvd_q[DVD_W-2:0], 1'b0};
          cnt_q <= cnt_q - 1'b1;
        end else begin
          quot  <= neg_q ? -$signed(mag_sat[COEF_W-1:0]) : $signed(mag_sat[COEF_W-1:0]);
          fin   <= 1'b1;
          run_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/gain_cal_sequencer.sv
module gain_cal_sequencer
  import gcal_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int SAMPLE_W      = 12,
  parameter int COARSE_STEPS  = 16,
  parameter int COARSE_STRIDE = 8,
  parameter int FINE_STEPS    = 128,
  parameter int FINE_STRIDE   = 1,
  parameter int FRAC_W        = 8,
  parameter int COEF_W        = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     sample_valid,
  output logic                     sample_ready,
  input  logic [SAMPLE_W-1:0]      sample_data,
  output logic [CODE_W-1:0]        ramp_code,
  output logic                     busy,
  output logic                     done,
  output logic signed [COEF_W-1:0] last_gain,
  output logic signed [COEF_W-1:0] last_offset,
  output logic signed [COEF_W-1:0] mid_gain,
  output logic signed [COEF_W-1:0] mid_offset
);
  localparam int MAX_STEPS = (COARSE_STEPS > FINE_STEPS) ? COARSE_STEPS : FINE_STEPS;
  localparam int NCNT_W    = $clog2(MAX_STEPS + 1);
  localparam int SX_W      = CODE_W + NCNT_W;
  localparam int SY_W      = SAMPLE_W + NCNT_W;
  localparam int SXX_W     = 2*CODE_W + NCNT_W;
  localparam int SXY_W     = CODE_W + SAMPLE_W + NCNT_W;
  localparam int PROD_W    = 2*CODE_W + SAMPLE_W + 2*NCNT_W + 1;
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1) <<< FRAC_W;

  cal_state_t state_q;
  cal_stage_t stage_q;

  logic                     xfer, acc_clr, at_end;
  logic [NCNT_W-1:0]        acc_n;
  logic [SX_W-1:0]          acc_sx;
  logic [SY_W-1:0]          acc_sy;
  logic [SXX_W-1:0]         acc_sxx;
  logic [SXY_W-1:0]         acc_sxy;
  logic [PROD_W-1:0]        p_nxy, p_xy, p_nxx, p_xx, p_xxy, p_xsxy;
  logic signed [PROD_W-1:0] num_q, onum_q, div_num;
  logic [PROD_W-1:0]        den_q;
  logic                     div_go, div_fin;
  logic signed [COEF_W-1:0] div_q;
  logic signed [COEF_W-1:0] pend_gain [2];
  logic signed [COEF_W-1:0] pend_ofs  [2];

  assign sample_ready = (state_q == ST_ACQ);
  assign busy         = (state_q != ST_IDLE);
  assign xfer         = sample_valid & sample_ready;
  assign acc_clr      = ((state_q == ST_IDLE) && start) ||
                        ((state_q == ST_WRAP) && (stage_q == STG_LAST));
  assign div_go       = (state_q == ST_GAIN_GO) || (state_q == ST_OFS_GO);
  assign div_num      = (state_q == ST_OFS_GO) ? onum_q : num_q;

  gcal_ramp #(
    .CODE_W(CODE_W), .COARSE_STEPS(COARSE_STEPS), .COARSE_STRIDE(COARSE_STRIDE),
    .FINE_STEPS(FINE_STEPS), .FINE_STRIDE(FINE_STRIDE)
  ) ramp_i (
    .clk(clk), .rst_n(rst_n), .clear(acc_clr), .advance(xfer),
    .fine(stage_q == STG_MID), .code(ramp_code), .at_end(at_end)
  );

  gcal_accum #(.CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W), .NCNT_W(NCNT_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clear(acc_clr), .take(xfer),
    .x(ramp_code), .y(sample_data),
    .n(acc_n), .sx(acc_sx), .sy(acc_sy), .sxx(acc_sxx), .sxy(acc_sxy)
  );

  gcal_div #(.NUM_W(PROD_W), .DEN_W(PROD_W), .FRAC_W(FRAC_W), .COEF_W(COEF_W)) div_i (
    .clk(clk), .rst_n(rst_n), .go(div_go), .numer(div_num), .denom(den_q),
    .fin(div_fin), .quot(div_q)
  );

  // Normal-equation products, taken once per stage in ST_SOLVE
  always_comb begin
    p_nxy  = PROD_W'(acc_n)   * PROD_W'(acc_sxy);
    p_xy   = PROD_W'(acc_sx)  * PROD_W'(acc_sy);
    p_nxx  = PROD_W'(acc_n)   * PROD_W'(acc_sxx);
    p_xx   = PROD_W'(acc_sx)  * PROD_W'(acc_sx);
    p_xxy  = PROD_W'(acc_sxx) * PROD_W'(acc_sy);
    p_xsxy = PROD_W'(acc_sx)  * PROD_W'(acc_sxy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      stage_q     <= STG_LAST;
      num_q       <= '0;
      onum_q      <= '0;
      den_q       <= '0;
      done        <= 1'b0;
      last_gain   <= UNITY;
      mid_gain    <= UNITY;
      last_offset <= '0;
      mid_offset  <= '0;
      for (int s = 0; s < 2; s++) begin
        pend_gain[s] <= UNITY;
        pend_ofs[s]  <= '0;
      end
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          stage_q <= STG_LAST;
          state_q <= ST_ACQ;
        end
        ST_ACQ: if (xfer && at_end) state_q <= ST_SOLVE;
        ST_SOLVE: begin
          num_q   <= $signed(p_nxy - p_xy);
          onum_q  <= $signed(p_xxy - p_xsxy);
          den_q   <= p_nxx - p_xx;
          state_q <= ST_GAIN_GO;
        end
        ST_GAIN_GO: state_q <= ST_GAIN_WAIT;
        ST_GAIN_WAIT: if (div_fin) begin
          pend_gain[stage_q] <= div_q;
          state_q <= ST_OFS_GO;
        end
        ST_OFS_GO: state_q <= ST_OFS_WAIT;
        ST_OFS_WAIT: if (div_fin) begin
          pend_ofs[stage_q] <= div_q;
          state_q <= ST_WRAP;
        end
        ST_WRAP: begin
          if (stage_q == STG_LAST) begin
            stage_q <= STG_MID;
            state_q <= ST_ACQ;
          end else begin
            last_gain   <= pend_gain[0];
            last_offset <= pend_ofs[0];
            mid_gain    <= pend_gain[1];
            mid_offset  <= pend_ofs[1];
            done        <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gcal_checker.sv
module gcal_checker #(
  parameter int CODE_W = 8,
  parameter int COEF_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     sample_valid,
  input logic                     sample_ready,
  input logic [CODE_W-1:0]        ramp_code,
  input logic                     busy,
  input logic                     done,
  input logic signed [COEF_W-1:0] last_gain,
  input logic signed [COEF_W-1:0] last_offset,
  input logic signed [COEF_W-1:0] mid_gain,
  input logic signed [COEF_W-1:0] mid_offset
);
  localparam logic [COEF_W-1:0] MOST_NEG = {1'b1, {(COEF_W-1){1'b0}}};

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R4
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) sample_ready |-> busy);
  // R3
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ready && !sample_valid) |=> $stable(ramp_code));
  // R3
  ramp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (ramp_code == '0));
  // R8
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(last_gain) && $stable(last_offset) && $stable(mid_gain) && $stable(mid_offset)));
  // R7
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_gain != MOST_NEG) && (last_offset != MOST_NEG) && (mid_gain != MOST_NEG) && (mid_offset != MOST_NEG));
endmodule

bind gain_cal_sequencer gcal_checker #(.CODE_W(CODE_W), .COEF_W(COEF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
  .sample_ready(sample_ready), .ramp_code(ramp_code), .busy(busy), .done(done),
  .last_gain(last_gain), .last_offset(last_offset), .mid_gain(mid_gain), .mid_offset(mid_offset)
);

// File: tb/gain_cal_sequencer_tb.sv
module gain_cal_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 8;
  localparam int SAMPLE_W = 12;
  localparam int FRAC_W = 8;
  localparam int COEF_W = 20;
  localparam int WATCHDOG = 150000;
  localparam longint LIM = (64'sd1 <<< (COEF_W-1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sample_valid = 1'b0;
  logic [SAMPLE_W-1:0] sample_data = '0;
  logic sample_ready, busy, done;
  logic [CODE_W-1:0] ramp_code;
  logic signed [COEF_W-1:0] last_gain, last_offset, mid_gain, mid_offset;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  longint old_lg, old_lo, old_mg, old_mo;
  longint s_n, s_x, s_y, s_xx, s_xy;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_cal_sequencer #(.CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .COEF_W(COEF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
    .sample_ready(sample_ready), .sample_data(sample_data), .ramp_code(ramp_code),
    .busy(busy), .done(done), .last_gain(last_gain), .last_offset(last_offset),
    .mid_gain(mid_gain), .mid_offset(mid_offset)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clamp(input longint v);
    if (v > LIM) return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  function automatic longint fit_gain();
    longint den = s_n*s_xx - s_x*s_x;
    return clamp(((s_n*s_xy - s_x*s_y) * (64'sd1 <<< FRAC_W)) / den);
  endfunction

  function automatic longint fit_ofs();
    longint den = s_n*s_xx - s_x*s_x;
    return clamp(((s_xx*s_y - s_x*s_xy) * (64'sd1 <<< FRAC_W)) / den);
  endfunction

  function automatic int shape(input int mode, input bit fine, input int x);
    int y;
    case (mode)
      0: y = 2*x + 5;
      1: y = fine ? 1500 - 3*x : (5*x)/8 + 7;
      2: y = fine ? ((x < 64) ? 4095 : 0) : x + (x*x)/64;
      default: y = fine ? (x*x)/16 : 1000 - 4*x;
    endcase
    if (y < 0) y = 0;
    if (y > 4095) y = 4095;
    return y;
  endfunction

  task automatic send_point(input int exp_x, input int y, input int gap);
    repeat (gap) @(negedge clk);
    sample_valid = 1'b1;
    sample_data  = SAMPLE_W'(y);
    while (!sample_ready) @(negedge clk);
    // R3 ramp code seen by this transfer
    check(ramp_code == CODE_W'(exp_x), "R3 ramp code", ramp_code, exp_x);
    @(negedge clk);
    sample_valid = 1'b0;
    // R4 ramp moved one step after the transfer (or wrapped)
    if (sample_ready && exp_x != 0)
      check(ramp_code != CODE_W'(exp_x), "R4 ramp advance", ramp_code, exp_x);
  endtask

  task automatic run_cal(input int mode, input int gap_mod, input int poke_at, input string name);
    longint eg[2], eo[2];
    int waited;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 busy follows start
    check(busy == 1'b1, {"R2 busy after start ", name}, busy, 1);
    for (int st = 0; st < 2; st++) begin
      int steps  = (st == 0) ? 16 : 128;
      int stride = (st == 0) ? 8 : 1;
      s_n = 0; s_x = 0; s_y = 0; s_xx = 0; s_xy = 0;
      for (int k = 0; k < steps; k++) begin
        int x = k * stride;
        int y = shape(mode, st == 1, x);
        if (st == 0 && k == poke_at) begin
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          // R8 restart while busy ignored
          check(busy == 1'b1, {"R8 busy kept ", name}, busy, 1);
        end
        send_point(x, y, (gap_mod > 0) ? (k % gap_mod) : 0);
        s_n++; s_x += x; s_y += y; s_xx += x*x; s_xy += x*y;
      end
      eg[st] = fit_gain();
      eo[st] = fit_ofs();
    end
    waited = 0;
    while (!done && waited < 2000) begin
      // R8 coefficients hold until done
      check(last_gain == old_lg && mid_offset == old_mo, {"R8 hold ", name}, last_gain, old_lg);
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, {"R11 done seen ", name}, done, 1);
    check(busy == 1'b0, {"R2 busy low at done ", name}, busy, 0);
    // R5 R9 gains per stage, R6 R9 offsets per stage
    check(last_gain == eg[0], {"R5 R9 last gain ", name}, last_gain, eg[0]);
    check(last_offset == eo[0], {"R6 R9 last offset ", name}, last_offset, eo[0]);
    check(mid_gain == eg[1], {"R5 R9 mid gain ", name}, mid_gain, eg[1]);
    check(mid_offset == eo[1], {"R6 R9 mid offset ", name}, mid_offset, eo[1]);
    @(negedge clk);
    check(done == 1'b0, {"R11 done one cycle ", name}, done, 0);
    old_lg = last_gain; old_lo = last_offset; old_mg = mid_gain; old_mo = mid_offset;
  endtask

  task automatic test_reset();
    // R1
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    check(sample_ready == 0, "R1 ready", sample_ready, 0);
    check(ramp_code == 0, "R1 ramp", ramp_code, 0);
    check(last_gain == 256 && mid_gain == 256, "R1 gain unity", last_gain, 256);
    check(last_offset == 0 && mid_offset == 0, "R1 offset zero", mid_offset, 0);
    old_lg = 256; old_mg = 256; old_lo = 0; old_mo = 0;
  endtask

  task automatic test_idle_samples();
    sample_valid = 1'b1;
    sample_data  = 12'hFFF;
    repeat (6) begin
      @(negedge clk);
      // R10 idle samples refused
      check(sample_ready == 0, "R10 ready idle", sample_ready, 0);
      check(ramp_code == 0, "R10 ramp idle", ramp_code, 0);
      check(mid_gain == old_mg && last_offset == old_lo, "R10 coef idle", mid_gain, old_mg);
    end
    sample_valid = 1'b0;
  endtask

  task automatic test_saturation();
    run_cal(2, 2, -1, "step");
    // R7 fine-ramp step response drives the offset to the limit
    check(mid_offset == LIM, "R7 offset saturated", mid_offset, LIM);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_cal(0, 0, -1, "line");
    test_idle_samples();
    run_cal(1, 3, 5, "slope+restart");
    test_saturation();
    run_cal(3, 4, -1, "curve");
    run_cal(0, 1, 15, "line again");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule